// File: doc/BRIEF.md
# Banked DAC Command Register Port

This block is the host side of a palette-DAC register file with sixteen byte-wide command registers but only four byte-wide I/O ports. The port the host touches supplies the two low bits of the register index, in the conventional DAC port order rather than numeric order. The low two bits of a separate 8-bit bank register supply the two high bits. The bank register's other six bits are kept for other users. The bank register can be written as a whole byte, or only in its two index bits.

One index is a status slot that has no storage of its own. It normally returns a live status byte supplied from outside. An extra command register sits behind that slot. It becomes visible only when bit 7 of command register 0 is set and the write-address register (index 0) holds 0x01. Reads are strobed and give a registered result one clock later. Writes take effect at the clock edge where they are strobed.

Top module: `dac_regport`

## Requirements
- R1: On reset all sixteen stored registers, the hidden extra register, the bank register and `rd_data` become 0x00.
- R2: `io_addr` 0x8, 0x9, 0x6 and 0x7 select low index bits 0, 1, 2 and 3. Any other `io_addr` value writes nothing, and a read there leaves `rd_data` unchanged.
- R3: The full index is `{bank_q[1:0], low bits}`. Writing one index and reading it back returns the written byte, and other indices keep their contents.
- R4: `bank_wr` loads all 8 bank bits. `bank_idx_wr` changes only bits 1:0 and keeps bits 7:2. When both are strobed, `bank_wr` wins.
- R5: `rd_data` shows the selected register in the cycle after `rd_en`. It holds its value while no mapped read is strobed.
- R6: While bit 7 of index 6 is 0, a read of index 10 returns `status_in` as sampled at the read edge.
- R7: While bit 7 of index 6 is 1 and index 0 holds 0x01, index 10 reads and writes the hidden extra register.
- R8: While bit 7 of index 6 is 1 and index 0 holds any value other than 0x01, index 10 returns `status_in`.
- R9: A write to index 10 while it shows status changes no storage. The hidden register keeps its value.
- R10: When `rd_en` and `wr_en` hit the same index in one cycle, `rd_data` returns the old contents and the new byte is stored.
- R11: Bank bits 7:2 have no effect on which register is addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr | input | 1 | Write the whole bank register |
| bank_idx_wr | input | 1 | Write only the bank index bits 1:0 |
| bank_wdata | input | 8 | Bank register write data (bits 1:0 used by `bank_idx_wr`) |
| bank_q | output | 8 | Current bank register |
| io_addr | input | 4 | Low nibble of the I/O port address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| status_in | input | 8 | Live status byte shown in the status slot |

## Verification
The hardest state to reach is the hidden extra register. Getting there takes three host accesses across three different banks: set bit 7 of command register 0 in bank 1, load 0x01 into the write address in bank 0, then access the status port in bank 2. The stimulus makes that walk. It then moves the write address to 0x00 and to a stray value, and writes the status slot while status shows there. Finally it unlocks again and reads the hidden register back, which shows that the ignored writes left it untouched.

// File: rtl/dac_regport.sv
module dac_regport #(
  parameter int DW        = 8,
  parameter int NREG      = 16,
  parameter int WADDR_IDX = 0,
  parameter int CMD0_IDX  = 6,
  parameter int STAT_IDX  = 10,
  parameter int UNLOCK_B  = 7,
  parameter logic [7:0] EXT_SEL = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_wr,
  input  logic          bank_idx_wr,
  input  logic [7:0]    bank_wdata,
  output logic [7:0]    bank_q,
  input  logic [3:0]    io_addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] status_in
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] ext_q;
  logic [1:0]    lo;
  logic          hit;
  logic [IW-1:0] idx;
  logic          unlock, ext_view, stat_slot;

  always_comb begin
    hit = 1'b1;
    lo  = 2'd0;
    case (io_addr)
      4'h8:    lo = 2'd0;
      4'h9:    lo = 2'd1;
      4'h6:    lo = 2'd2;
      4'h7:    lo = 2'd3;
      default: hit = 1'b0;
    endcase
  end

  assign idx       = {bank_q[1:0], lo};
  assign unlock    = rf[CMD0_IDX][UNLOCK_B];
  assign ext_view  = unlock && (rf[WADDR_IDX] == EXT_SEL);
  assign stat_slot = (idx == IW'(STAT_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bank_q <= '0;
    else if (bank_wr)
      bank_q <= bank_wdata;
    else if (bank_idx_wr)
      bank_q <= {bank_q[7:2], bank_wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      ext_q <= '0;
    end else if (wr_en && hit) begin
      if (!stat_slot)
        rf[idx] <= wr_data;
      else if (ext_view)
        ext_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en && hit)
      rd_data <= !stat_slot ? rf[idx] : (ext_view ? ext_q : status_in);
  end
endmodule

module dac_regport_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bank_wr,
  input logic          bank_idx_wr,
  input logic [7:0]    bank_q,
  input logic [3:0]    io_addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] status_in,
  input logic          unlock,
  input logic          ext_view,
  input logic [DW-1:0] ext_q
);
  logic mapped, slot10;
  assign mapped = (io_addr == 4'h8) || (io_addr == 4'h9) || (io_addr == 4'h6) || (io_addr == 4'h7);
  assign slot10 = (bank_q[1:0] == 2'd2) && (io_addr == 4'h6);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && bank_q == 8'h00));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && mapped) |=> $stable(rd_data));

  assert_bank_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_idx_wr && !bank_wr) |=> (bank_q[7:2] == $past(bank_q[7:2])));

  assert_status_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot10 && !unlock) |=> (rd_data == $past(status_in)));

  assert_ext_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot10 && ext_view) |=> (ext_q == $past(wr_data)));

  assert_ext_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot10 && !ext_view) |=> $stable(ext_q));
endmodule

bind dac_regport dac_regport_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_idx_wr(bank_idx_wr),
  .bank_q(bank_q), .io_addr(io_addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .status_in(status_in),
  .unlock(unlock), .ext_view(ext_view), .ext_q(ext_q)
);

// File: tb/test_dac_regport.sv
module test_dac_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_wr = 1'b0, bank_idx_wr = 1'b0;
  logic [7:0] bank_wdata = '0, bank_q;
  logic [3:0] io_addr = 4'h0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data, status_in = 8'h5A;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_regport i_dac_regport (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_idx_wr(bank_idx_wr),
    .bank_wdata(bank_wdata), .bank_q(bank_q), .io_addr(io_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .status_in(status_in)
  );

  // op[21:20] 0=bank byte write, 1=port write, 2=port read+check; addr, data, expected
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'h0, 8'h00, 8'h00},
    {2'd1, 4'h8, 8'h11, 8'h00},
    {2'd1, 4'h9, 8'h22, 8'h00},
    {2'd1, 4'h6, 8'h33, 8'h00},
    {2'd1, 4'h7, 8'h44, 8'h00},
    {2'd2, 4'h8, 8'h00, 8'h11},
    {2'd2, 4'h9, 8'h00, 8'h22},
    {2'd2, 4'h6, 8'h00, 8'h33},
    {2'd2, 4'h7, 8'h00, 8'h44},
    {2'd0, 4'h0, 8'hFD, 8'h00},
    {2'd1, 4'h8, 8'h55, 8'h00},
    {2'd2, 4'h8, 8'h00, 8'h55},
    {2'd2, 4'h9, 8'h00, 8'h00},
    {2'd0, 4'h0, 8'h02, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'h5A},
    {2'd1, 4'h6, 8'h99, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'h5A},
    {2'd0, 4'h0, 8'h03, 8'h00},
    {2'd1, 4'h8, 8'h66, 8'h00},
    {2'd2, 4'h8, 8'h00, 8'h66},
    {2'd2, 4'h7, 8'h00, 8'h00},
    {2'd0, 4'h0, 8'h00, 8'h00},
    {2'd2, 4'h8, 8'h00, 8'h11}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bank_set(input logic [7:0] v);
    @(negedge clk); bank_wr = 1'b1; bank_wdata = v;
    @(negedge clk); bank_wr = 1'b0;
  endtask

  task automatic io_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; io_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic io_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; io_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'h00);
    check("R1 bank after reset", bank_q, 8'h00);
    rst_n = 1'b1;
    io_read(4'h8, r);
    check("R1 index 0 after reset", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][21:20])
        2'd0: bank_set(VEC[i][15:8]);
        2'd1: io_write(VEC[i][19:16], VEC[i][15:8]);
        default: begin
          io_read(VEC[i][19:16], r);
          check($sformatf("R3/R5/R6/R11 table row %0d", i), r, VEC[i][7:0]);
        end
      endcase
    end

    // unlock hidden register: CR0 bit7 in bank 1, write-address 0x01 in bank 0
    bank_set(8'h01); io_write(4'h6, 8'h80);
    bank_set(8'h00); io_write(4'h8, 8'h01);
    bank_set(8'h02);
    io_read(4'h6, r);
    check("R9 hidden untouched by status-view write", r, 8'h00);
    io_write(4'h6, 8'hC3);
    io_read(4'h6, r);
    check("R7 hidden register read back", r, 8'hC3);

    bank_set(8'h00); io_write(4'h8, 8'h00);
    bank_set(8'h02); status_in = 8'hA5;
    io_read(4'h6, r);
    check("R8 addr 0x00 shows status", r, 8'hA5);
    bank_set(8'h00); io_write(4'h8, 8'h05);
    bank_set(8'h02);
    io_read(4'h6, r);
    check("R8 stray addr shows status", r, 8'hA5);
    io_write(4'h6, 8'h77);
    bank_set(8'h00); io_write(4'h8, 8'h01);
    bank_set(8'h02);
    io_read(4'h6, r);
    check("R9 status-view write ignored", r, 8'hC3);

    bank_set(8'h01); io_write(4'h6, 8'h00);
    bank_set(8'h02); status_in = 8'h3C;
    io_read(4'h6, r);
    check("R6 locked slot shows status", r, 8'h3C);

    // unmapped port
    bank_set(8'h00);
    io_read(4'h8, r);
    io_write(4'hA, 8'hEE);
    io_read(4'hA, r);
    check("R2 unmapped read holds rd_data", r, 8'h01);
    io_read(4'h9, r);
    check("R2 unmapped write stored nothing", r, 8'h22);

    // bank index-only write
    bank_set(8'hF0);
    @(negedge clk); bank_idx_wr = 1'b1; bank_wdata = 8'h03;
    @(negedge clk); bank_idx_wr = 1'b0;
    check("R4 index write keeps upper bits", bank_q, 8'hF3);
    @(negedge clk); bank_idx_wr = 1'b1; bank_wr = 1'b1; bank_wdata = 8'h0D;
    @(negedge clk); bank_idx_wr = 1'b0; bank_wr = 1'b0;
    check("R4 byte write wins", bank_q, 8'h0D);

    // simultaneous read and write, bank 1 index 5
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; io_addr = 4'h9; wr_data = 8'hB7;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check("R10 read returns old", rd_data, 8'h00);
    io_read(4'h9, r);
    check("R10 new value stored", r, 8'hB7);

    // reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 rd_data cleared", rd_data, 8'h00);
    check("R1 bank cleared", bank_q, 8'h00);
    rst_n = 1'b1;
    io_read(4'h9, r);
    check("R1 index 1 cleared", r, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule